// File: doc/BRIEF.md
# Byte-Wide CRC-16 Engine with Programmable Seed

This block computes a 16-bit cyclic redundancy check over a message of bytes, using the generator x^16 + x^12 + x^5 + 1 (0x1021). Software first writes a 16-bit starting value. That write discards any earlier remainder. Software then presents message bytes, one per clock cycle, on a data port with a valid strobe. The running remainder is always visible on a 16-bit read port, and that value is the checksum itself.

Each byte is consumed most significant bit first, with no reflection of bits. The remainder is updated directly in feedback-shift form, so the message needs no trailing zero bits and the result is never inverted. The seed selects among the common flavours of this checksum. Seed 0x0000 gives the plain form and seed 0xFFFF the usual preset form. Seed 0x1D0F reproduces the results of the variant that presets to 0xFFFF and appends sixteen zero bits. An acknowledge output tells the writer, in the same cycle, whether its byte was taken.

Top module: `crc16_engine`

## Requirements
- R1: While reset is asserted (rstN low), the remainder reads 0x0000 and byteAck stays low, even if dataValid is high.
- R2: A cycle with seedWr high makes crcOut equal seedVal from the next clock edge on.
- R3: When seedWr and dataValid are both high in one cycle, the seed is loaded, byteAck is low in that cycle, and that cycle's dataByte has no effect on the remainder.
- R4: A cycle with dataValid high and seedWr low makes byteAck high in that same cycle. It folds all 8 bits of dataByte into the remainder, bit 7 first. At each bit, the feedback is (data bit XOR remainder bit 15); the remainder shifts left one place and is XORed with 0x1021 when the feedback is 1. The new remainder appears on crcOut after the next clock edge.
- R5: In a cycle with neither seedWr nor dataValid high, crcOut keeps its value whatever dataByte holds.
- R6: The bytes 0x31..0x39 ("123456789") give 0x31C3 after seed 0x0000, 0x29B1 after seed 0xFFFF, and 0xE5CC after seed 0x1D0F.
- R7: The single byte 0x41 gives 0x58E5 after seed 0x0000, 0xB915 after seed 0xFFFF, and 0x9479 after seed 0x1D0F.
- R8: 256 bytes of 0x41 give 0xABE3 after seed 0x0000, 0xEA0B after seed 0xFFFF, and 0xE938 after seed 0x1D0F.
- R9: After seed 0x1D0F, the result equals that of a plain shift register preset to 0xFFFF that is clocked with the message bits followed by 16 zero bits.
- R10: Bytes arriving on consecutive cycles are each accepted, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| seedWr | input | 1 | Load strobe for the starting value |
| seedVal | input | 16 | Starting value for the remainder |
| dataValid | input | 1 | Strobe marking dataByte as a message byte |
| dataByte | input | 8 | Message byte, bit 7 sent first |
| byteAck | output | 1 | High in a cycle whose byte is taken |
| crcOut | output | 16 | Current remainder, which is the checksum |

## Verification
The hardest case to reach from the ports is a seed write that collides with a valid byte. In that cycle the byte must be dropped, not folded in after the load. The stimulus loads one seed and, in the next cycle, raises both strobes with a different seed and a nonzero byte. It then checks that the acknowledge was low and that the readback equals the second seed exactly. Long runs of back-to-back bytes test that the pipeline holds no state beyond the remainder. The zero-augmented equivalence is checked against a separately coded shift-register model that is fed 16 extra zero bits.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic loadSeed;
    logic foldByte;
  } crcCtrl_t;

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     seedWr,
  input  logic     dataValid,
  output crcCtrl_t ctrl,
  output logic     byteAck
);

  // The seed write wins; the byte in a colliding cycle is dropped.
  always_comb begin
    ctrl.loadSeed = rstN & seedWr;
    ctrl.foldByte = rstN & dataValid & ~seedWr;
  end

  assign byteAck = ctrl.foldByte;

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadSeed, ctrl.foldByte}));

  // R3
  seed_blocks_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedWr |-> !byteAck);

  // R1
  reset_no_ack_chk: assert property (@(posedge clk)
    !rstN |-> !byteAck);

endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] RESET_VAL = '0
)(
  input  logic              clk,
  input  logic              rstN,
  input  crcCtrl_t          ctrl,
  input  logic [CRC_W-1:0]  seedVal,
  input  logic [DATA_W-1:0] dataByte,
  output logic [CRC_W-1:0]  remainder
);

  localparam int MSB = CRC_W - 1;

  // stage[0] is the current remainder; stage[DATA_W] has every bit folded in.
  logic [DATA_W:0][CRC_W-1:0] stage;

  assign stage[0] = remainder;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic feedback;
    assign feedback = dataByte[DATA_W-1-i] ^ stage[i][MSB];
    assign stage[i+1] = {stage[i][MSB-1:0], 1'b0} ^ (feedback ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              remainder <= RESET_VAL;
    else if (ctrl.loadSeed) remainder <= seedVal;
    else if (ctrl.foldByte) remainder <= stage[DATA_W];
  end

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadSeed |=> remainder == $past(seedVal));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadSeed && !ctrl.foldByte |=> $stable(remainder));

  // R4
  zero_fold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.foldByte && remainder == '0 && dataByte == '0 |=> remainder == '0);

  // R1
  reset_value_chk: assert property (@(posedge clk)
    $rose(rstN) |-> remainder == RESET_VAL);

endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              seedWr,
  input  logic [CRC_W-1:0]  seedVal,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataByte,
  output logic              byteAck,
  output logic [CRC_W-1:0]  crcOut
);

  crcCtrl_t ctrl;

  crc16_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .seedWr    (seedWr),
    .dataValid (dataValid),
    .ctrl      (ctrl),
    .byteAck   (byteAck)
  );

  crc16_datapath #(
    .CRC_W     (CRC_W),
    .DATA_W    (DATA_W),
    .POLY      (POLY),
    .RESET_VAL ('0)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .seedVal   (seedVal),
    .dataByte  (dataByte),
    .remainder (crcOut)
  );

endmodule

// File: tb/crc16_engine_test.sv
module crc16_engine_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        seedWr;
  logic [15:0] seedVal;
  logic        dataValid;
  logic [7:0]  dataByte;
  logic        byteAck;
  logic [15:0] crcOut;

  int checks = 0;
  int failures = 0;
  int cycCount = 0;
  logic [15:0] cur;

  typedef struct {
    logic [15:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycCount++;

  crc16_engine uut (
    .clk(clk), .rstN(rstN), .seedWr(seedWr), .seedVal(seedVal),
    .dataValid(dataValid), .dataByte(dataByte), .byteAck(byteAck), .crcOut(crcOut)
  );

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Feedback-shift reference, MSB first, straight from R4.
  function automatic logic [15:0] refStep(logic [15:0] r, logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = b[k] ^ r[15];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // Plain shift register with augmentation, for R9.
  function automatic logic [15:0] augStep(logic [15:0] r, logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      logic top;
      top = r[15];
      r = {r[14:0], b[k]};
      if (top) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // Monitor: compares the queued expectations once their cycle has come.
  always @(negedge clk) begin
    #2;
    while (sb.size() > 0 && sb[0].due <= cycCount) begin
      item_t it;
      it = sb.pop_front();
      check(crcOut, it.exp, it.tag);
    end
  end

  task automatic drive(bit sw, logic [15:0] sv, bit dv, logic [7:0] db,
                       logic [15:0] exp, bit expAck, string tag);
    item_t it;
    @(negedge clk);
    seedWr = sw; seedVal = sv; dataValid = dv; dataByte = db;
    #1;
    checks++;
    if (byteAck !== expAck) begin
      failures++;
      $display("FAIL %s ack actual=%b expected=%b", tag, byteAck, expAck);
    end
    it.exp = exp; it.due = cycCount + 1; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic loadSeed(logic [15:0] s);
    cur = s;
    drive(1'b1, s, 1'b0, 8'h00, s, 1'b0, "R2 seed load");
  endtask

  task automatic feed(logic [7:0] b);
    cur = refStep(cur, b);
    drive(1'b0, 16'h0000, 1'b1, b, cur, 1'b1, "R4 R10 byte fold");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      drive(1'b0, 16'hBEEF, 1'b0, 8'(8'hA5 + i), cur, 1'b0, "R5 idle hold");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] seeds [3];
    logic [15:0] digitsExp [3];
    logic [15:0] oneAExp [3];
    logic [15:0] manyAExp [3];
    logic [15:0] aug;

    seeds = '{16'h0000, 16'hFFFF, 16'h1D0F};
    digitsExp = '{16'h31C3, 16'h29B1, 16'hE5CC};
    oneAExp = '{16'h58E5, 16'hB915, 16'h9479};
    manyAExp = '{16'hABE3, 16'hEA0B, 16'hE938};

    // R1: reset with a byte offered
    rstN = 1'b0; seedWr = 1'b0; seedVal = 16'h0; dataValid = 1'b1; dataByte = 8'h77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(crcOut, 16'h0000, "R1 reset remainder");
    check({15'd0, byteAck}, 16'h0000, "R1 ack low in reset");
    dataValid = 1'b0;
    rstN = 1'b1;
    cur = 16'h0000;
    idle(2);

    for (int s = 0; s < 3; s++) begin
      loadSeed(seeds[s]);
      for (int c = 0; c < 9; c++) feed(8'(8'h31 + c));
      idle(2);
      check(crcOut, digitsExp[s], "R6 digits result");

      loadSeed(seeds[s]);
      feed(8'h41);
      idle(1);
      check(crcOut, oneAExp[s], "R7 single A result");

      loadSeed(seeds[s]);
      for (int c = 0; c < 256; c++) feed(8'h41);
      idle(1);
      check(crcOut, manyAExp[s], "R8 256 A result");
    end

    // R3: seed write collides with a byte
    loadSeed(16'h1234);
    feed(8'h5A);
    cur = 16'hABCD;
    drive(1'b1, 16'hABCD, 1'b1, 8'h55, 16'hABCD, 1'b0, "R3 seed priority");
    idle(1);
    check(crcOut, 16'hABCD, "R3 byte dropped");
    feed(8'h00);
    idle(1);

    // R9: seed 0x1D0F against augmented model preset 0xFFFF
    aug = 16'hFFFF;
    for (int c = 0; c < 9; c++) aug = augStep(aug, 8'(8'h31 + c));
    aug = augStep(aug, 8'h00);
    aug = augStep(aug, 8'h00);
    loadSeed(16'h1D0F);
    for (int c = 0; c < 9; c++) feed(8'(8'h31 + c));
    idle(1);
    check(crcOut, aug, "R9 augmented equivalence digits");

    aug = 16'hFFFF;
    for (int c = 0; c < 5; c++) aug = augStep(aug, 8'(8'hC3 ^ (c * 8'h1F)));
    aug = augStep(aug, 8'h00);
    aug = augStep(aug, 8'h00);
    loadSeed(16'h1D0F);
    for (int c = 0; c < 5; c++) feed(8'(8'hC3 ^ (c * 8'h1F)));
    idle(1);
    check(crcOut, aug, "R9 augmented equivalence mixed");

    idle(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule